// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, every cycle, whether the front of a five-stage pipeline may advance. Branch and jump decisions in this pipeline are made in decode. The block looks at three kinds of producer that may be about to write a register: a load in execute, any register-writing instruction in execute, and a load one stage later in memory. It compares each producer's destination against the two source fields of the instruction waiting in decode.

When a value cannot reach decode or execute in time, the block freezes the program counter and the fetch/decode register and sends a bubble into the decode/execute register. When a jump is decoded, or a branch resolves as taken, it squashes the instruction just fetched by zeroing the instruction word held in the fetch/decode register.

The outputs are pure combinational functions of the current inputs. The clock and reset only time the embedded property checks. The two-cycle stall for a load that feeds a branch comes about naturally: the load first matches in execute and then again in memory.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When `exMemRead` is 1 and `exRt` is nonzero and equals `idRs` or `idRt`, a stall is raised whether or not decode holds a branch.
- R2: During a stall `pcWrite` and `ifidWrite` are both 0. Outside a stall both are 1.
- R3: `bubble` is 1 exactly in the cycles where a stall is raised, and 0 otherwise.
- R4: When `idBranch` is 1, `exRegWrite` is 1 and `exDest` is nonzero and equals `idRs` or `idRt`, a stall is raised. The same match with `idBranch` 0 and `exMemRead` 0 raises no stall.
- R5: When `idBranch` is 1, `memMemRead` is 1 and `memDest` is nonzero and equals `idRs` or `idRt`, a stall is raised. The same match with `idBranch` 0 raises no stall.
- R6: A match in which the producing register number is 0 never raises a stall.
- R7: With no stall, `idJump` = 1 drives `ifFlush` to 1.
- R8: With no stall, `idBranch` = 1 together with `idTaken` = 1 drives `ifFlush` to 1. With `idTaken` = 0 it stays 0.
- R9: `ifFlush` is never 1 while `ifidWrite` is 0. When a stall and a flush request coincide, the stall wins and the flush appears in the first cycle that has no stall.
- R10: With no producer match and no jump or taken branch, the outputs are `pcWrite`=1, `ifidWrite`=1, `bubble`=0, `ifFlush`=0.
- R11: A branch that reads a register loaded by the instruction right before it is stalled for two consecutive cycles: first with the load in execute, then with it in memory. In the third cycle it proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the embedded checks |
| rst_n | input | 1 | Active-low reset that disables the checks |
| exMemRead | input | 1 | Instruction in execute is a load |
| exRt | input | REG_W | Load target field of the instruction in execute |
| exRegWrite | input | 1 | Instruction in execute writes a register |
| exDest | input | REG_W | Destination register of the instruction in execute |
| memMemRead | input | 1 | Instruction in memory stage is a load |
| memDest | input | REG_W | Destination register of the instruction in memory stage |
| idRs | input | REG_W | First source field of the instruction in decode |
| idRt | input | REG_W | Second source field of the instruction in decode |
| idBranch | input | 1 | Decode holds a conditional branch |
| idJump | input | 1 | Decode holds an unconditional jump |
| idTaken | input | 1 | Decode-stage compare found the branch taken |
| pcWrite | output | 1 | Program counter update enable |
| ifidWrite | output | 1 | Fetch/decode register load enable |
| bubble | output | 1 | Zero the control bits entering decode/execute |
| ifFlush | output | 1 | Zero the instruction word in fetch/decode |

## Verification
The bench aims at the cases where gating on `idBranch` matters. An ALU result or a memory-stage load meeting a non-branch must pass through, or the pipeline would lose cycles that forwarding already covers. The same producers meeting a branch must stall, or the compare would read a stale value. It checks register-zero matches, which a careless comparator would turn into needless stalls. It also checks a jump or taken branch arriving during a stall; a design without stall precedence would squash the held instruction and lose it. Finally it steps a load into a following branch through both stall cycles and the release. A design that only checked execute would let the branch go one cycle early.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

  // Raw producer hits found by the comparator datapath
  typedef struct packed {
    logic exLoadHit;   // load in execute targets a decode source
    logic exWriteHit;  // any writer in execute targets a decode source
    logic memLoadHit;  // load in memory stage targets a decode source
  } hz_hits_t;

  // Strobes handed to the pipeline registers
  typedef struct packed {
    logic pcWrite;
    logic ifidWrite;
    logic bubble;
    logic ifFlush;
  } hz_strobe_t;

endpackage

// File: rtl/pipe_hazard_match.sv
module pipe_hazard_match
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] exRt,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] exDest,
  input  logic             memMemRead,
  input  logic [REG_W-1:0] memDest,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  output hz_hits_t         hits
);

  localparam int NUM_PROD = 3;
  localparam int NUM_SRC  = 2;

  logic [NUM_PROD-1:0]            prodValid;
  logic [NUM_PROD-1:0][REG_W-1:0] prodReg;
  logic [NUM_SRC-1:0][REG_W-1:0]  srcReg;
  logic [NUM_PROD-1:0]            prodHit;

  assign prodValid = {memMemRead, exRegWrite, exMemRead};
  assign prodReg   = {memDest, exDest, exRt};
  assign srcReg    = {idRt, idRs};

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    logic [NUM_SRC-1:0] srcEq;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign srcEq[s] = (prodReg[p] == srcReg[s]);
    end
    // register zero is hard-wired and never a real dependency
    assign prodHit[p] = prodValid[p] && (prodReg[p] != '0) && (|srcEq);
  end

  assign hits.exLoadHit  = prodHit[0];
  assign hits.exWriteHit = prodHit[1];
  assign hits.memLoadHit = prodHit[2];

  // R6: a zero-numbered producer never reports a hit
  assert_zero_reg_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exRt == '0 && exDest == '0 && memDest == '0) |-> (hits == '0));

  // R1: a load in execute naming a decode source always reports a hit
  assert_load_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (exMemRead && exRt != '0 && (exRt == idRs || exRt == idRt)) |-> hits.exLoadHit);

endmodule

// File: rtl/pipe_hazard_fsm.sv
module pipe_hazard_fsm
  import pipe_hazard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hz_hits_t   hits,
  input  logic       idBranch,
  input  logic       idJump,
  input  logic       idTaken,
  output hz_strobe_t strobe
);

  logic branchHold;
  logic stall;
  logic redirect;

  // a decode-stage compare needs its operands before execute finishes
  assign branchHold = idBranch && (hits.exWriteHit || hits.memLoadHit);
  assign stall      = hits.exLoadHit || branchHold;
  assign redirect   = idJump || (idBranch && idTaken);

  always_comb begin
    strobe.pcWrite   = !stall;
    strobe.ifidWrite = !stall;
    strobe.bubble    = stall;
    // a held instruction is never squashed; the flush waits for release
    strobe.ifFlush   = redirect && !stall;
  end

  // R9: flush and hold never hit the fetch/decode register together
  assert_flush_not_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ifFlush |-> strobe.ifidWrite);

  // R2: both front-end enables move together
  assert_enables_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.pcWrite == strobe.ifidWrite);

  // R3: a bubble is injected exactly when the front end is frozen
  assert_bubble_on_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.bubble != strobe.pcWrite);

  // R4: a branch meeting an execute-stage writer is held
  assert_branch_alu_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idBranch && hits.exWriteHit) |-> !strobe.pcWrite);

  // R7: a jump with no hazard squashes the fetched slot
  assert_jump_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idJump && hits == '0) |-> strobe.ifFlush);

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exMemRead,
  input  logic [REG_W-1:0] exRt,
  input  logic             exRegWrite,
  input  logic [REG_W-1:0] exDest,
  input  logic             memMemRead,
  input  logic [REG_W-1:0] memDest,
  input  logic [REG_W-1:0] idRs,
  input  logic [REG_W-1:0] idRt,
  input  logic             idBranch,
  input  logic             idJump,
  input  logic             idTaken,
  output logic             pcWrite,
  output logic             ifidWrite,
  output logic             bubble,
  output logic             ifFlush
);

  hz_hits_t   hits;
  hz_strobe_t strobe;

  pipe_hazard_match #(.REG_W(REG_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .exMemRead  (exMemRead),
    .exRt       (exRt),
    .exRegWrite (exRegWrite),
    .exDest     (exDest),
    .memMemRead (memMemRead),
    .memDest    (memDest),
    .idRs       (idRs),
    .idRt       (idRt),
    .hits       (hits)
  );

  pipe_hazard_fsm u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hits     (hits),
    .idBranch (idBranch),
    .idJump   (idJump),
    .idTaken  (idTaken),
    .strobe   (strobe)
  );

  assign pcWrite   = strobe.pcWrite;
  assign ifidWrite = strobe.ifidWrite;
  assign bubble    = strobe.bubble;
  assign ifFlush   = strobe.ifFlush;

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;

  localparam int REG_W = 5;
  localparam logic [3:0] IDLE  = 4'b1100;
  localparam logic [3:0] HOLD  = 4'b0010;
  localparam logic [3:0] FLUSH = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exMemRead, exRegWrite, memMemRead, idBranch, idJump, idTaken;
  logic [REG_W-1:0] exRt, exDest, memDest, idRs, idRt;
  logic pcWrite, ifidWrite, bubble, ifFlush;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .exMemRead(exMemRead), .exRt(exRt), .exRegWrite(exRegWrite), .exDest(exDest),
    .memMemRead(memMemRead), .memDest(memDest), .idRs(idRs), .idRt(idRt),
    .idBranch(idBranch), .idJump(idJump), .idTaken(idTaken),
    .pcWrite(pcWrite), .ifidWrite(ifidWrite), .bubble(bubble), .ifFlush(ifFlush)
  );

  task automatic clear();
    exMemRead = 0; exRegWrite = 0; memMemRead = 0;
    idBranch = 0; idJump = 0; idTaken = 0;
    exRt = 0; exDest = 0; memDest = 0; idRs = 0; idRt = 0;
  endtask

  // drive on the falling edge, sample five ns later, well away from the rising edge
  task automatic expect_out(string req, logic [3:0] exp);
    logic [3:0] got;
    #5;
    got = {pcWrite, ifidWrite, bubble, ifFlush};
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic t_reset_idle();
    @(negedge clk); clear();
    expect_out("R10 idle after reset", IDLE);
    idRs = 3; idRt = 4; exDest = 7; exRegWrite = 1; memDest = 9; memMemRead = 1;
    expect_out("R10 unrelated producers", IDLE);
  endtask

  task automatic t_load_use();
    @(negedge clk); clear();
    exMemRead = 1; exRegWrite = 1; exRt = 6; exDest = 6; idRs = 6; idRt = 2;
    expect_out("R1 R2 R3 load-use on rs", HOLD);
    @(negedge clk); idRs = 1; idRt = 6;
    expect_out("R1 load-use on rt", HOLD);
    @(negedge clk); clear();
    exMemRead = 1; exRt = 6; idRs = 1; idRt = 2;
    expect_out("R1 load no match", IDLE);
  endtask

  task automatic t_branch_alu();
    @(negedge clk); clear();
    exRegWrite = 1; exDest = 8; idRs = 8; idRt = 3; idBranch = 1;
    expect_out("R4 branch after alu writer", HOLD);
    @(negedge clk); idBranch = 0;
    expect_out("R4 non-branch after alu writer", IDLE);
  endtask

  task automatic t_branch_mem_load();
    @(negedge clk); clear();
    memMemRead = 1; memDest = 12; idRs = 5; idRt = 12; idBranch = 1;
    expect_out("R5 branch after mem-stage load", HOLD);
    @(negedge clk); idBranch = 0;
    expect_out("R5 non-branch after mem-stage load", IDLE);
  endtask

  task automatic t_zero_reg();
    @(negedge clk); clear();
    exMemRead = 1; exRt = 0; exRegWrite = 1; exDest = 0;
    memMemRead = 1; memDest = 0; idRs = 0; idRt = 0; idBranch = 1;
    expect_out("R6 register zero no stall", IDLE);
  endtask

  task automatic t_flushes();
    @(negedge clk); clear();
    idJump = 1;
    expect_out("R7 jump flush", FLUSH);
    @(negedge clk); clear();
    idBranch = 1; idTaken = 1; idRs = 2; idRt = 3;
    expect_out("R8 taken branch flush", FLUSH);
    @(negedge clk); idTaken = 0;
    expect_out("R8 untaken branch no flush", IDLE);
  endtask

  task automatic t_precedence();
    @(negedge clk); clear();
    exMemRead = 1; exRt = 4; idRs = 4; idJump = 1;
    expect_out("R9 jump during load-use held", HOLD);
    @(negedge clk); exMemRead = 0;
    expect_out("R9 jump flushes after release", FLUSH);
    @(negedge clk); clear();
    exRegWrite = 1; exDest = 9; idRs = 9; idBranch = 1; idTaken = 1;
    expect_out("R9 taken branch held", HOLD);
  endtask

  task automatic t_load_then_branch();
    @(negedge clk); clear();
    // cycle 1: load in execute, branch reads its target
    exMemRead = 1; exRegWrite = 1; exRt = 10; exDest = 10; idRs = 10; idRt = 1; idBranch = 1;
    expect_out("R11 first stall cycle", HOLD);
    // cycle 2: load moved to memory stage, bubble in execute
    @(negedge clk);
    exMemRead = 0; exRegWrite = 0; exRt = 0; exDest = 0;
    memMemRead = 1; memDest = 10;
    expect_out("R11 second stall cycle", HOLD);
    // cycle 3: load in writeback, branch resolves taken
    @(negedge clk);
    memMemRead = 0; memDest = 0; idTaken = 1;
    expect_out("R11 release and flush", FLUSH);
  endtask

  initial begin
    clear();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset_idle();
    t_load_use();
    t_branch_alu();
    t_branch_mem_load();
    t_zero_reg();
    t_flushes();
    t_precedence();
    t_load_then_branch();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule